// File: doc/BRIEF.md
# Encoded System Clock Divider Tree

This block turns one fast system clock and two rate ticks (one at crystal rate, one at PLL rate) into three clock-enable pulse streams: a core enable, a bus enable and a peripheral enable. Each stream is a single-cycle pulse on the fast clock. A 32-bit configuration word picks the tick source and sets three divisors. Each divisor is a small encoded field that is looked up in a fixed table. Downstream logic qualifies its flops with these enables instead of running on separate derived clocks.

The core and bus dividers count ticks of the selected source. The peripheral divider counts bus enables, so its period is the bus period times its own divisor. The configuration word is held in an internal copy. That copy is reloaded only when all three dividers finish a period on the same tick. Because of this, a change of configuration never cuts a period short on any output.

Top module: `sysclk_divtree`

## Requirements
- R1: Bit 23 of the active configuration chooses the tick source: 1 selects `pll_tick`, 0 selects `xtal_tick`. The unselected tick has no effect on any output.
- R2: The core divisor comes from bits 27:25. Codes 0..7 map to 1, 2, 4, 8, 16, 1, 1, 1, so codes 5, 6 and 7 behave as divide by one. `core_en` pulses once for every core-divisor selected ticks.
- R3: The bus divisor comes from bits 22:20. Codes 0..7 map to 1, 2, 4, 5, 6, 8, 16, 32. `bus_en` pulses once for every bus-divisor selected ticks.
- R4: The peripheral divisor comes from bits 19:18. Codes 0..3 map to 1, 2, 4, 8. The peripheral divider counts bus enables, not source ticks. `per_en` is only ever high in a cycle where `bus_en` is also high.
- R5: An enable is high for exactly one fast-clock cycle: the cycle that follows the clock edge at which the completing selected tick was sampled. With no selected tick, no enable rises.
- R6: A new value on `cfg_word` is taken only on a selected tick where all three dividers complete a period together. Before that tick, the change has no effect on pulse spacing or on source choice.
- R7: Synchronous active-high reset clears all counters and enables and loads `cfg_word` as the active configuration. The first pulse of each output comes after a full divide period counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration word (source select and three divisor codes) |
| xtal_tick | input | 1 | One-cycle tick at crystal rate |
| pll_tick | input | 1 | One-cycle tick at PLL rate |
| core_en | output | 1 | Core clock enable pulse |
| bus_en | output | 1 | Bus clock enable pulse |
| per_en | output | 1 | Peripheral clock enable pulse |

## Verification
The assertions rely on three assumptions about the inputs:
- Each tick input is high for at most one fast-clock cycle per rate event.
- `cfg_word` may change at any time.
- Reset is held for at least one clock edge before the block runs.

The stimulus drives ticks and configuration only on falling edges. It holds reset across a full edge at the start of every phase. It also changes `cfg_word` in the middle of running periods, so the deferred reload is exercised, not avoided. A reference model counts selected ticks since the last reload and predicts each enable from the divisor tables. This gives a cycle-by-cycle comparison for every code of every table.

// File: rtl/sysclk_divtree_pkg.sv
package sysclk_divtree_pkg;

   localparam int CODE3_W = 3;
   localparam int CODE2_W = 2;

   // Core table: upper codes saturate at divide-by-one.
   function automatic int unsigned core_ratio(input logic [CODE3_W-1:0] code);
      case (code)
         3'd0:    core_ratio = 1;
         3'd1:    core_ratio = 2;
         3'd2:    core_ratio = 4;
         3'd3:    core_ratio = 8;
         3'd4:    core_ratio = 16;
         default: core_ratio = 1;
      endcase
   endfunction

   // Bus table: includes the non-power-of-two ratios 5 and 6.
   function automatic int unsigned bus_ratio(input logic [CODE3_W-1:0] code);
      case (code)
         3'd0:    bus_ratio = 1;
         3'd1:    bus_ratio = 2;
         3'd2:    bus_ratio = 4;
         3'd3:    bus_ratio = 5;
         3'd4:    bus_ratio = 6;
         3'd5:    bus_ratio = 8;
         3'd6:    bus_ratio = 16;
         default: bus_ratio = 32;
      endcase
   endfunction

   function automatic int unsigned per_ratio(input logic [CODE2_W-1:0] code);
      case (code)
         2'd0:    per_ratio = 1;
         2'd1:    per_ratio = 2;
         2'd2:    per_ratio = 4;
         default: per_ratio = 8;
      endcase
   endfunction

endpackage

// File: rtl/sysclk_divtree_src.sv
module sysclk_divtree_src (
   input  logic sel_pll,
   input  logic xtal_tick,
   input  logic pll_tick,
   output logic src_tick
);
   always_comb begin
      src_tick = sel_pll ? pll_tick : xtal_tick;
   end
endmodule

// File: rtl/sysclk_divtree_cfg.sv
module sysclk_divtree_cfg #(
   parameter int CFG_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CFG_W-1:0] cfg_in,
   output logic [CFG_W-1:0] cfg_act
);
   always_ff @(posedge clk) begin
      if (rst || load) begin
         cfg_act <= cfg_in;
      end
   end
endmodule

// File: rtl/sysclk_divtree_ctr.sv
module sysclk_divtree_ctr #(
   parameter int DW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   input  logic [DW-1:0] ratio,
   output logic          wrap
);
   logic [DW-1:0] cnt;
   logic [DW-1:0] last;

   always_comb begin
      last = ratio - DW'(1);
      wrap = step && (cnt == last);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= (cnt == last) ? '0 : cnt + DW'(1);
      end
   end

   // R3 (and R2, R4): the count stays inside the selected period
   a_r3_cnt_below_ratio: assert property (@(posedge clk) disable iff (rst)
      cnt < ratio)
      else $error("counter reached its ratio");
endmodule

// File: rtl/sysclk_divtree.sv
module sysclk_divtree
   import sysclk_divtree_pkg::*;
#(
   parameter int CFG_W    = 32,
   parameter int SEL_BIT  = 23,
   parameter int CORE_LSB = 25,
   parameter int BUS_LSB  = 20,
   parameter int PER_LSB  = 18,
   parameter int DW       = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             xtal_tick,
   input  logic             pll_tick,
   output logic             core_en,
   output logic             bus_en,
   output logic             per_en
);
   localparam int MAX_RATIO = 32;

   generate
      if (SEL_BIT >= CFG_W || CORE_LSB + CODE3_W > CFG_W ||
          BUS_LSB + CODE3_W > CFG_W || PER_LSB + CODE2_W > CFG_W) begin : g_bad_field
         $error("configuration field lies outside the word");
      end
      if ((1 << DW) <= MAX_RATIO) begin : g_bad_width
         $error("counter width too small for largest ratio");
      end
   endgenerate

   logic [CFG_W-1:0] act;
   logic             src_tick;
   logic [DW-1:0]    core_r, bus_r, per_r;
   logic             core_wrap, bus_wrap, per_wrap, reload;

   sysclk_divtree_cfg #(.CFG_W(CFG_W)) u_cfg (
      .clk(clk), .rst(rst), .load(reload), .cfg_in(cfg_word), .cfg_act(act)
   );

   sysclk_divtree_src u_src (
      .sel_pll(act[SEL_BIT]), .xtal_tick(xtal_tick), .pll_tick(pll_tick),
      .src_tick(src_tick)
   );

   always_comb begin
      core_r = DW'(core_ratio(act[CORE_LSB +: CODE3_W]));
      bus_r  = DW'(bus_ratio(act[BUS_LSB +: CODE3_W]));
      per_r  = DW'(per_ratio(act[PER_LSB +: CODE2_W]));
   end

   sysclk_divtree_ctr #(.DW(DW)) u_core (
      .clk(clk), .rst(rst), .step(src_tick), .ratio(core_r), .wrap(core_wrap)
   );
   sysclk_divtree_ctr #(.DW(DW)) u_bus (
      .clk(clk), .rst(rst), .step(src_tick), .ratio(bus_r), .wrap(bus_wrap)
   );
   // Peripheral divider steps on bus completions (cascade).
   sysclk_divtree_ctr #(.DW(DW)) u_per (
      .clk(clk), .rst(rst), .step(bus_wrap), .ratio(per_r), .wrap(per_wrap)
   );

   always_comb begin
      reload = core_wrap && bus_wrap && per_wrap;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         core_en <= 1'b0;
         bus_en  <= 1'b0;
         per_en  <= 1'b0;
      end else begin
         core_en <= core_wrap;
         bus_en  <= bus_wrap;
         per_en  <= per_wrap;
      end
   end

   // R4: peripheral pulses only coincide with bus pulses
   a_r4_per_with_bus: assert property (@(posedge clk) disable iff (rst)
      per_en |-> bus_en)
      else $error("peripheral pulse without bus pulse");

   // R5: every enable follows a sampled selected tick
   a_r5_core_after_tick: assert property (@(posedge clk) disable iff (rst)
      core_en |-> $past(src_tick))
      else $error("core pulse without tick");
   a_r5_bus_after_tick: assert property (@(posedge clk) disable iff (rst)
      bus_en |-> $past(src_tick))
      else $error("bus pulse without tick");

   // R7: outputs quiet in the cycle after reset
   a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !(core_en || bus_en || per_en))
      else $error("pulse right after reset");

   // R6: active configuration changes only at a common completion
   a_r6_cfg_held: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$past(reload) |-> $stable(act))
      else $error("configuration changed mid-period");
endmodule

// File: tb/sysclk_divtree_bench.sv
module sysclk_divtree_bench;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] cfg_word = '0;
   logic        xtal_tick = 1'b0;
   logic        pll_tick = 1'b0;
   logic        core_en, bus_en, per_en;

   always #(PERIOD/2) clk = ~clk;

   sysclk_divtree u_sysclk_divtree (
      .clk(clk), .rst(rst), .cfg_word(cfg_word), .xtal_tick(xtal_tick),
      .pll_tick(pll_tick), .core_en(core_en), .bus_en(bus_en), .per_en(per_en)
   );

   int compared = 0;
   int mismatched = 0;
   bit done = 0;
   string tag = "R7";
   logic [2:0] expq[$];
   string      tagq[$];

   // reference model state
   logic [31:0] m_act = '0;
   int          m_t = 0;

   function automatic int tb_core(input int c);
      int t[8] = '{1, 2, 4, 8, 16, 1, 1, 1};
      return t[c];
   endfunction
   function automatic int tb_bus(input int c);
      int t[8] = '{1, 2, 4, 5, 6, 8, 16, 32};
      return t[c];
   endfunction
   function automatic int tb_per(input int c);
      int t[4] = '{1, 2, 4, 8};
      return t[c];
   endfunction

   function automatic logic [31:0] mk(input bit pll, input int c, input int b, input int p);
      logic [31:0] w = '0;
      w[23]    = pll;
      w[27:25] = c[2:0];
      w[22:20] = b[2:0];
      w[19:18] = p[1:0];
      return w;
   endfunction

   // driver: one fast-clock step, pushes the expected enables
   task automatic step(input bit r, input logic [31:0] cfg, input bit xt, input bit pt);
      logic [2:0] e;
      bit src, ce, be, pe;
      int cd, bd, pd;
      @(negedge clk);
      rst = r; cfg_word = cfg; xtal_tick = xt; pll_tick = pt;
      e = '0;
      if (r) begin
         m_act = cfg;
         m_t = 0;
      end else begin
         src = m_act[23] ? pt : xt;
         if (src) begin
            m_t++;
            cd = tb_core(int'(m_act[27:25]));
            bd = tb_bus(int'(m_act[22:20]));
            pd = tb_per(int'(m_act[19:18]));
            ce = (m_t % cd) == 0;
            be = (m_t % bd) == 0;
            pe = (m_t % (bd * pd)) == 0;
            e = {ce, be, pe};
            if (ce && be && pe) begin
               m_t = 0;
               m_act = cfg;
            end
         end
      end
      expq.push_back(e);
      tagq.push_back(tag);
   endtask

   // run n cycles: pll tick every pk cycles, xtal tick every xk cycles
   task automatic run(input logic [31:0] cfg, input int n, input int pk, input int xk);
      for (int i = 0; i < n; i++) begin
         step(1'b0, cfg, (i % xk) == 0, (i % pk) == 0);
      end
   endtask

   task automatic do_reset(input logic [31:0] cfg);
      step(1'b1, cfg, 1'b0, 1'b0);
      step(1'b1, cfg, 1'b0, 1'b0);
   endtask

   // monitor: compares after each rising edge
   always @(posedge clk) begin
      #2;
      if (expq.size() > 0) begin
         logic [2:0] e;
         string t;
         e = expq.pop_front();
         t = tagq.pop_front();
         compared++;
         if ({core_en, bus_en, per_en} !== e) begin
            mismatched++;
            $display("FAIL %s at %0t: core/bus/per actual %b%b%b expected %b",
                     t, $time, core_en, bus_en, per_en, e);
         end
      end
   end

   initial begin
      // R7: reset state, then first pulses after a full period
      tag = "R7";
      do_reset(mk(1, 2, 3, 1));
      run(mk(1, 2, 3, 1), 50, 1, 1);

      // R2: every core code, ticks every cycle and every 2 cycles
      tag = "R2";
      for (int c = 0; c < 8; c++) begin
         do_reset(mk(1, c, 0, 0));
         run(mk(1, c, 0, 0), 40, (c % 2) + 1, 7);
      end

      // R3: every bus code, R4: with different peripheral codes
      tag = "R3";
      for (int b = 0; b < 8; b++) begin
         do_reset(mk(1, 1, b, 0));
         run(mk(1, 1, b, 0), 80, 1, 5);
      end
      tag = "R4";
      for (int p = 0; p < 4; p++) begin
         do_reset(mk(1, 0, 3, p));
         run(mk(1, 0, 3, p), 100, 1, 3);
         do_reset(mk(1, 4, 4, p));
         run(mk(1, 4, 4, p), 120, 1, 3);
      end

      // R1: crystal selected while PLL ticks fast, then PLL selected
      tag = "R1";
      do_reset(mk(0, 1, 1, 1));
      run(mk(0, 1, 1, 1), 80, 1, 3);
      do_reset(mk(1, 1, 1, 1));
      run(mk(1, 1, 1, 1), 80, 4, 1);

      // R5: sparse ticks, and no ticks at all
      tag = "R5";
      do_reset(mk(1, 0, 0, 0));
      run(mk(1, 0, 0, 0), 40, 3, 1000);
      for (int i = 0; i < 30; i++) step(1'b0, mk(1, 0, 0, 0), 1'b1, 1'b0);

      // R6: change config mid-period, including source and ratio 5
      tag = "R6";
      do_reset(mk(1, 3, 3, 2));
      run(mk(1, 3, 3, 2), 7, 1, 1);
      run(mk(0, 0, 4, 0), 200, 1, 2);
      run(mk(1, 4, 7, 3), 30, 1, 1);
      run(mk(1, 0, 0, 0), 400, 1, 1);

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         done = 1;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule